// File: doc/BRIEF.md
# Tagged Fan-In / Fan-Out Pipeline Router

This block collects operand pairs from several independent producer ports and funnels them into one shared three-stage pipeline. Each item is stamped, on entry, with the number of the port that delivered it. That stamp rides alongside the data through every stage unchanged. At the pipeline exit it selects which consumer port receives the result.

Producers and consumers each use a valid/ready handshake. A word moves on a rising edge where both signals are high. A round-robin arbiter admits at most one producer per cycle. The pipeline is elastic: a stage moves forward only when the stage ahead of it is empty or is itself moving. The pipeline head leaves only when the consumer named by its stamp is ready. The arithmetic is a placeholder, a wrap-around integer sum of the two operands. It stands in for a heavier fixed-latency unit.

Top module: `tag_router`

## Requirements
- R1: A synchronous active-high reset empties every stage, so all `out_valid` bits are low afterwards. It also points the arbiter at port 0, so when every producer requests at once after reset, port 0 is admitted first.
- R2: In any cycle at most one `in_ready` bit is high, and only for a port whose `in_valid` is high. Grants rotate round-robin: after port p is admitted, the next grant goes to the first requesting port found by searching upward from p+1 and wrapping past the highest port to 0. With all ports requesting continuously from reset, the grant order is 0,1,2,3,0.
- R3: A result carries a tag equal to the index of the input port it entered on. The tag field of output port p reads p whenever `out_valid[p]` is high.
- R4: The result is `z = a + b` modulo 2^DW. The operands are taken from bits [p*DW +: DW] of `in_a`/`in_b` for input port p.
- R5: A result is offered only on the output port named by its tag. At most one `out_valid` bit is high in any cycle.
- R6: For each port, results leave in the same order as their operands were accepted.
- R7: When nothing stalls, a result is valid on its output after the third rising edge, counting the edge that accepted its operands. A new item can be accepted every cycle.
- R8: While the head result's consumer holds `out_ready` low, the result and its `out_valid` stay unchanged. No result for any other port appears before it.
- R9: Producers may insert 0 to 3 idle cycles between items, and consumers may apply backpressure at any time. No item is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NPORT | Producer p offers an item |
| in_ready | output | NPORT | Block admits producer p's item this cycle |
| in_a | input | NPORT*DW | First operand of each producer, port p at [p*DW +: DW] |
| in_b | input | NPORT*DW | Second operand of each producer, port p at [p*DW +: DW] |
| out_valid | output | NPORT | Consumer p is offered a result |
| out_ready | input | NPORT | Consumer p accepts the offered result |
| out_z | output | NPORT*DW | Result seen by consumer p at [p*DW +: DW] |
| out_tag | output | NPORT*IW | Source-port tag seen by consumer p at [p*IW +: IW] |

## Verification
A directed run holds all four producers busy from reset to expose the grant rotation. A single lone item measures the empty-pipe latency. A pinned stall holds the head for port 0 behind items for the other ports, which separates a true pipeline freeze from overtaking. A sweep then crosses producer gaps of 0 or up to 3 cycles with three consumer patterns: always ready, random readiness, and a rotating per-port stall. Every delivered word is compared with the sum computed from its port and sequence number. That comparison catches a wrong sum, a wrong tag, reordering, loss or duplication.

// File: rtl/tag_router.sv
module tag_router #(
  parameter int NPORT = 4,
  parameter int DW    = 32,
  parameter int DEPTH = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPORT-1:0]          in_valid,
  output logic [NPORT-1:0]          in_ready,
  input  logic [NPORT*DW-1:0]       in_a,
  input  logic [NPORT*DW-1:0]       in_b,
  output logic [NPORT-1:0]          out_valid,
  input  logic [NPORT-1:0]          out_ready,
  output logic [NPORT*DW-1:0]       out_z,
  output logic [NPORT*$clog2(NPORT)-1:0] out_tag
);
  localparam int IW = $clog2(NPORT);

  logic [DEPTH-1:0] sv, adv;
  logic [DW-1:0]    sz [DEPTH];
  logic [IW-1:0]    st [DEPTH];
  logic [IW-1:0]    ptr, gidx;
  logic             gany, s0_free, fire;

  always_comb begin
    int j;
    gany = 1'b0;
    gidx = ptr;
    for (int k = 0; k < NPORT; k++) begin
      j = (int'(ptr) + k) % NPORT;
      if (!gany && in_valid[j]) begin
        gany = 1'b1;
        gidx = IW'(j);
      end
    end
  end

  always_comb begin
    adv[DEPTH-1] = sv[DEPTH-1] & out_ready[st[DEPTH-1]];
    for (int i = DEPTH-2; i >= 0; i--)
      adv[i] = sv[i] & (~sv[i+1] | adv[i+1]);
  end

  assign s0_free  = ~sv[0] | adv[0];
  assign fire     = gany & s0_free;
  assign in_ready = {NPORT{fire}} & (NPORT'(1) << gidx);

  always_ff @(posedge clk) begin
    if (rst) begin
      sv  <= '0;
      ptr <= '0;
    end else begin
      if (fire) ptr <= (int'(gidx) == NPORT-1) ? '0 : gidx + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if ((i == 0) ? fire : adv[(i == 0) ? 0 : i-1]) sv[i] <= 1'b1;
        else if (adv[i])                               sv[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      sz[0] <= in_a[gidx*DW +: DW] + in_b[gidx*DW +: DW];
      st[0] <= gidx;
    end
    for (int i = 1; i < DEPTH; i++)
      if (adv[i-1]) begin
        sz[i] <= sz[i-1];
        st[i] <= st[i-1];
      end
  end

  assign out_valid = {NPORT{sv[DEPTH-1]}} & (NPORT'(1) << st[DEPTH-1]);
  assign out_z     = {NPORT{sz[DEPTH-1]}};
  assign out_tag   = {NPORT{st[DEPTH-1]}};

  assert_grant_needs_request_R2: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == '0);

  assert_single_output_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_valid));

  assert_empty_after_reset_R1: assert property (@(posedge clk)
    rst |=> out_valid == '0);

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    assert_tag_matches_port_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid[p] |-> out_tag[p*IW +: IW] == IW'(p));

    assert_hold_when_blocked_R8: assert property (@(posedge clk) disable iff (rst)
      (out_valid[p] && !out_ready[p]) |=> (out_valid[p] && $stable(out_z[p*DW +: DW])));
  end
endmodule

// File: tb/sim_tag_router.sv
module sim_tag_router;
  logic         clk = 1'b0, rst = 1'b1;
  logic [3:0]   iv = '0, ordy = '0;
  logic [3:0]   in_ready, out_valid;
  logic [127:0] ia = '0, ib = '0, out_z;
  logic [7:0]   out_tag;

  tag_router #(.NPORT(4), .DW(32), .DEPTH(3)) u0 (
    .clk(clk), .rst(rst), .in_valid(iv), .in_ready(in_ready),
    .in_a(ia), .in_b(ib), .out_valid(out_valid), .out_ready(ordy),
    .out_z(out_z), .out_tag(out_tag));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, gapmax = 0, mode = 0, gn = 0;
  int sent[4], recvd[4], total[4], gapc[4], acc_cyc[4], out_cyc[4], glog[16];
  bit acc[4];
  bit done = 0, prev_stall = 0;
  logic [3:0]   prev_ov;
  logic [127:0] prev_z;

  function automatic logic [31:0] opa(int p, int i);
    return (32'(p) << 28) ^ (32'(i) * 32'h0123_4567) ^ ((i % 2 == 1) ? 32'hFFFF_0000 : 32'h0);
  endfunction
  function automatic logic [31:0] opb(int p, int i);
    return 32'hF000_0000 + 32'(i) * 32'h00AB_CDEF + 32'(p);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      if (acc[p]) begin
        iv[p] = 1'b0; acc[p] = 1'b0;
        gapc[p] = int'($urandom_range(gapmax, 0));
      end
      if (!iv[p] && sent[p] < total[p]) begin
        if (gapc[p] > 0) gapc[p]--;
        else begin
          iv[p] = 1'b1;
          ia[p*32 +: 32] = opa(p, sent[p]);
          ib[p*32 +: 32] = opb(p, sent[p]);
        end
      end
    end
    case (mode)
      0: ordy = 4'hF;
      1: ordy = 4'($urandom);
      2: for (int p = 0; p < 4; p++) ordy[p] = (((cyc / 4) + p) % 4) != 0;
      default: ordy = 4'b1110;
    endcase
    #1;
    chk($onehot0(in_ready) && ((in_ready & ~iv) == 0), "R2 grant", in_ready, in_ready & iv);
    chk($countones(out_valid) <= 1, "R5 single output", out_valid, 0);
    if (prev_stall)
      chk(out_valid == prev_ov && out_z == prev_z, "R8 hold", out_valid, prev_ov);
    for (int p = 0; p < 4; p++) begin
      if (out_valid[p]) begin
        chk(out_tag[p*2 +: 2] == 2'(p), "R3 tag", out_tag[p*2 +: 2], p);
        out_cyc[p] = cyc;
        if (ordy[p]) begin
          chk(out_z[p*32 +: 32] == opa(p, recvd[p]) + opb(p, recvd[p]), "R4 R6 sum/order",
              out_z[p*32 +: 32], opa(p, recvd[p]) + opb(p, recvd[p]));
          recvd[p]++;
        end
      end
    end
    prev_stall = |(out_valid & ~ordy);
    prev_ov = out_valid;
    prev_z  = out_z;
    for (int p = 0; p < 4; p++)
      if (iv[p] && in_ready[p]) begin
        acc[p] = 1'b1; sent[p]++; acc_cyc[p] = cyc;
        if (gn < 16) glog[gn] = p;
        gn++;
      end
    cyc++;
  endtask

  function automatic bit all_done();
    for (int p = 0; p < 4; p++) if (recvd[p] < total[p]) return 0;
    return 1;
  endfunction

  task automatic drain();
    for (int k = 0; k < 20000 && !all_done(); k++) step();
    repeat (4) step();
    for (int p = 0; p < 4; p++)
      chk(recvd[p] == total[p] && sent[p] == total[p], "R9 no loss", recvd[p], total[p]);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin
      sent[p] = 0; recvd[p] = 0; total[p] = 0; gapc[p] = 0; acc[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 4'b0, "R1 reset empty", out_valid, 0);
    chk(in_ready == 4'b0, "R1 idle ready", in_ready, 0);

    // R1 R2: all ports contend from reset
    gn = 0;
    for (int p = 0; p < 4; p++) total[p] = 3;
    drain();
    chk(glog[0] == 0, "R1 first grant", glog[0], 0);
    for (int k = 1; k < 5; k++)
      chk(glog[k] == k % 4, "R2 rotation", glog[k], k % 4);

    // R7: lone item into an empty pipe
    total[2] += 1;
    drain();
    chk(out_cyc[2] - acc_cyc[2] == 3, "R7 latency", out_cyc[2] - acc_cyc[2], 3);

    // R8: port 0 blocked, others must not overtake
    mode = 3;
    total[0] += 1;
    repeat (5) step();
    for (int p = 1; p < 4; p++) total[p] += 1;
    begin
      int r1, r2, r3;
      r1 = recvd[1]; r2 = recvd[2]; r3 = recvd[3];
      repeat (10) step();
      chk(out_valid == 4'b0001, "R8 head pinned", out_valid, 1);
      chk(recvd[1] == r1 && recvd[2] == r2 && recvd[3] == r3, "R8 no overtake",
          recvd[1] + recvd[2] + recvd[3], r1 + r2 + r3);
    end
    mode = 0;
    drain();

    // R9 sweep: gaps x consumer patterns
    foreach (glog[k]) glog[k] = 0;
    for (int g = 0; g < 2; g++)
      for (int m = 0; m < 3; m++) begin
        gapmax = (g == 0) ? 0 : 3;
        mode = m;
        for (int p = 0; p < 4; p++) total[p] += 20;
        drain();
      end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule